// File: doc/BRIEF.md
# Tree Reduction and Prefix-Scan Index Scheduler

This block walks the fixed sequence of operand pairs needed to combine a vector of N elements, either down to one value (tree reduction) or into a running inclusive scan (work-efficient prefix sum). It is loaded with a length, a 2-bit submode and two inversion bits, and a start pulse. It then emits one element index per operation, either the left or the right operand of each pair, as the submode selects. The arithmetic, any masking and all register-file traffic belong to the host.

A host that needs both operands of every pair runs two copies in lockstep, one with a left submode and one with the matching right submode. A running operation count is kept. A one-cycle completion pulse follows the last emitted index. Lengths need not be powers of two. Optional inversions mirror the indices so the result gathers in the last element, or make a reduction fold from a large stride downward.

Top module: `tree_sched`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are low and `op_count` is zero.
- R2: `cfg_sub` encoding: 2'b00 gives the reduction left index, 2'b01 the reduction right index, 2'b10 the scan left index and 2'b11 the scan right index. For N=4, plain reduction, the left stream is 0,2,0 and the right stream is 1,3,2.
- R3: A reduction with both inversion bits clear runs passes with stride s = 2, 4, 8, … while s/2 < N. Each pass pairs left i with right i+s/2 for i = 0, s, 2s, … while i+s/2 < N. Accumulating right into left leaves the total in element 0 after N−1 operations.
- R4: `cfg_inv[0]` maps every index x to N−1−x. When it is set, the result lands in element N−1 and each left index exceeds its right index. When it is clear, each left index is below its right index.
- R5: A reduction with `cfg_inv[1]` set folds instead. Its half-stride h starts at the largest power of two below N and halves down to 1. Each pass pairs i with i+h for i = 0, 1, … while i < h and i+h < N. It also takes N−1 operations and leaves the total in element 0.
- R6: A scan first runs an up-sweep over strides s = 2, 4, … ≤ N, pairing (i+s/2−1, i+s−1). It then runs a down-sweep from s = P (the largest power of two ≤ N) down to 2, pairing (i+s−1, i+s+s/2−1). In both sweeps i steps by s while the right index is below N. Adding left into right gives an inclusive scan. `cfg_inv[1]` has no effect on scans.
- R7: Any length from 1 to MAX_LEN is accepted, including non-powers of two. N=1 produces no operation and still signals completion.
- R8: `op_count` is cleared at an accepted start and rises by one with each `out_valid`. `done` pulses for one cycle after the last index, when `op_count` equals the total operations (at most 127).
- R9: A start with length 0 or above MAX_LEN emits no index, leaves `op_count` at 0 and raises `done` two cycles after the start.
- R10: `start` while `busy` is ignored: the running schedule continues unchanged.
- R11: Every emitted index is below N, so elements outside the schedule are never addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a schedule with the current configuration (accepted only when idle) |
| cfg_len | input | LEN_W | Element count N |
| cfg_sub | input | 2 | Submode: family and operand side |
| cfg_inv | input | 2 | Bit 0 mirrors indices, bit 1 selects folding reduction |
| busy | output | 1 | A schedule is in progress |
| out_valid | output | 1 | `out_idx` carries an operand index this cycle |
| out_idx | output | IDX_W | Operand element index |
| op_count | output | CNT_W | Operations emitted since the last start |
| done | output | 1 | One-cycle pulse after the final operation |

## Verification
Every length from 1 to 32 is run under all four inversion settings for both families. The left and right streams are compared against an arithmetic pair list. The pairs are then applied to distinct sample data, which tells a correct combining order apart from a merely plausible list of indices. Powers of two and lengths one above them expose off-by-one stride bounds. The mirrored settings distinguish left/right ordering. The folding mode and the scan down-sweep have their own empty or partial passes that only odd lengths reach. Separate runs cover the longest scan, the rejected lengths 0 and MAX_LEN+1, and a start pulsed mid-schedule with different settings.

// File: rtl/tree_sched_pkg.sv
package tree_sched_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} walk_st_t;
  typedef enum logic [1:0] {K_RED_UP, K_RED_FOLD, K_PS_UP, K_PS_DN} pass_kind_t;
  localparam int OP_LIMIT = 127;
endpackage

// File: rtl/tree_sched_pair.sv
module tree_sched_pair
  import tree_sched_pkg::*;
#(
  parameter int AW = 9,
  parameter int EW = 3
) (
  input  pass_kind_t      kind,
  input  logic [EW-1:0]   ex,
  input  logic [AW-1:0]   pos,
  input  logic [AW-1:0]   len,
  output logic            ok,
  output logic [AW-1:0]   lft,
  output logic [AW-1:0]   rgt,
  output logic [AW-1:0]   step
);
  logic [AW-1:0] s, h;

  always_comb begin
    s = AW'(1) << ex;
    h = s >> 1;
    case (kind)
      K_RED_UP: begin
        lft  = pos;
        rgt  = pos + h;
        ok   = rgt < len;
        step = s;
      end
      K_RED_FOLD: begin
        lft  = pos;
        rgt  = pos + h;
        ok   = (pos < h) && (rgt < len);
        step = AW'(1);
      end
      K_PS_UP: begin
        lft  = pos + h - AW'(1);
        rgt  = pos + s - AW'(1);
        ok   = rgt < len;
        step = s;
      end
      default: begin
        lft  = pos + s - AW'(1);
        rgt  = pos + s + h - AW'(1);
        ok   = rgt < len;
        step = s;
      end
    endcase
  end
endmodule

// File: rtl/tree_sched_walk.sv
module tree_sched_walk
  import tree_sched_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = 7,
  parameter int IDX_W   = 6,
  parameter int EW      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [1:0]       cfg_sub,
  input  logic [1:0]       cfg_inv,
  output logic             load,
  output logic             emit,
  output logic             fin,
  output logic             busy,
  output logic [IDX_W-1:0] lft,
  output logic [IDX_W-1:0] rgt,
  output logic [LEN_W-1:0] n_q,
  output logic [1:0]       sub_q,
  output logic [1:0]       inv_q
);
  localparam int AW = LEN_W + 2;

  walk_st_t      st;
  pass_kind_t    kind;
  logic          phase;
  logic [EW-1:0] ex, eq_q, ep_q;
  logic [AW-1:0] pos, lft_w, rgt_w, step_w;
  logic          ok;

  // smallest e with 2^e >= v
  function automatic logic [EW-1:0] ceil_exp(input logic [LEN_W-1:0] v);
    logic [EW-1:0] e;
    e = '0;
    for (int k = 0; k < LEN_W; k++)
      if ((AW'(1) << k) < AW'(v)) e = EW'(k + 1);
    return e;
  endfunction

  // largest e with 2^e <= v
  function automatic logic [EW-1:0] floor_exp(input logic [LEN_W-1:0] v);
    logic [EW-1:0] e;
    e = '0;
    for (int k = 0; k < LEN_W; k++)
      if ((AW'(1) << k) <= AW'(v)) e = EW'(k);
    return e;
  endfunction

  always_comb begin
    if (!sub_q[1]) kind = inv_q[1] ? K_RED_FOLD : K_RED_UP;
    else           kind = phase ? K_PS_DN : K_PS_UP;
    eq_q = ceil_exp(n_q);
    ep_q = floor_exp(n_q);
  end

  tree_sched_pair #(.AW(AW), .EW(EW)) u_pair (
    .kind (kind),
    .ex   (ex),
    .pos  (pos),
    .len  (AW'(n_q)),
    .ok   (ok),
    .lft  (lft_w),
    .rgt  (rgt_w),
    .step (step_w)
  );

  assign load = (st == ST_IDLE) && start;
  assign emit = (st == ST_RUN) && ok;
  assign fin  = (st == ST_FIN);
  assign busy = (st != ST_IDLE);
  assign lft  = IDX_W'(lft_w);
  assign rgt  = IDX_W'(rgt_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      phase <= 1'b0;
      ex    <= '0;
      pos   <= '0;
      n_q   <= '0;
      sub_q <= '0;
      inv_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          n_q   <= cfg_len;
          sub_q <= cfg_sub;
          inv_q <= cfg_inv;
          pos   <= '0;
          phase <= 1'b0;
          ex    <= (!cfg_sub[1] && cfg_inv[1]) ? ceil_exp(cfg_len) : EW'(1);
          st    <= (cfg_len < LEN_W'(2) || cfg_len > LEN_W'(MAX_LEN)) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (ok) begin
            pos <= pos + step_w;
          end else begin
            pos <= '0;
            case (kind)
              K_RED_UP:   if (ex == eq_q) st <= ST_FIN; else ex <= ex + EW'(1);
              K_RED_FOLD: if (ex == EW'(1)) st <= ST_FIN; else ex <= ex - EW'(1);
              K_PS_UP:    if (ex == ep_q) phase <= 1'b1; else ex <= ex + EW'(1);
              default:    if (ex == EW'(1)) st <= ST_FIN; else ex <= ex - EW'(1);
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tree_sched_sel.sv
module tree_sched_sel #(
  parameter int LEN_W = 7,
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] lft,
  input  logic [IDX_W-1:0] rgt,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       sub,
  input  logic [1:0]       inv,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] pick;
  always_comb begin
    pick = sub[0] ? rgt : lft;
    if (inv[0]) idx = IDX_W'(len - LEN_W'(1) - LEN_W'(pick));
    else        idx = pick;
  end
endmodule

// File: rtl/tree_sched.sv
module tree_sched
  import tree_sched_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int CNT_W   = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [1:0]       cfg_sub,
  input  logic [1:0]       cfg_inv,
  output logic             busy,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic [CNT_W-1:0] op_count,
  output logic             done
);
  localparam int EW = $clog2(LEN_W + 1);

  logic             load, emit, fin;
  logic [IDX_W-1:0] lft, rgt, idx;
  logic [LEN_W-1:0] n_q;
  logic [1:0]       sub_q, inv_q;

  tree_sched_walk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W), .EW(EW)) u_walk (
    .clk(clk), .rst(rst), .start(start),
    .cfg_len(cfg_len), .cfg_sub(cfg_sub), .cfg_inv(cfg_inv),
    .load(load), .emit(emit), .fin(fin), .busy(busy),
    .lft(lft), .rgt(rgt), .n_q(n_q), .sub_q(sub_q), .inv_q(inv_q)
  );

  tree_sched_sel #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_sel (
    .lft(lft), .rgt(rgt), .len(n_q), .sub(sub_q), .inv(inv_q), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      op_count  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= emit;
      done      <= fin;
      if (emit) out_idx <= idx;
      if (load)      op_count <= '0;
      else if (emit) op_count <= op_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tree_sched_chk.sv
module tree_sched_chk
  import tree_sched_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = 7,
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [LEN_W-1:0] cfg_len,
  input logic             busy,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_idx,
  input logic [CNT_W-1:0] op_count,
  input logic             done
);
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else if (start && !busy) len_q <= cfg_len;
  end

  AST_IDX_RANGE:  assert property (@(posedge clk) disable iff (rst) out_valid |-> LEN_W'(out_idx) < len_q); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_DONE_IDLE:  assert property (@(posedge clk) disable iff (rst) done |-> (!busy && !out_valid)); // R8
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst) out_valid |-> busy); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) out_valid |-> op_count == CNT_W'($past(op_count) + CNT_W'(1))); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst) ($past(busy) && !out_valid) |-> $stable(op_count)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) op_count <= CNT_W'(OP_LIMIT)); // R8
  AST_REJECT:     assert property (@(posedge clk) disable iff (rst)
                    (start && !busy && (cfg_len == '0 || cfg_len > LEN_W'(MAX_LEN))) |=> !out_valid ##1 done); // R9
endmodule

bind tree_sched tree_sched_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len), .busy(busy),
  .out_valid(out_valid), .out_idx(out_idx), .op_count(op_count), .done(done)
);

// File: tb/sim_tree_sched.sv
module sim_tree_sched;
  localparam int CLK_P   = 10;
  localparam int MAX_LEN = 64;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int CNT_W   = LEN_W + 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [1:0] cfg_sub = '0, cfg_inv = '0;
  logic busy, out_valid, done;
  logic [IDX_W-1:0] out_idx;
  logic [CNT_W-1:0] op_count;

  always #(CLK_P/2) clk = ~clk;

  tree_sched #(.MAX_LEN(MAX_LEN)) u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len), .cfg_sub(cfg_sub),
    .cfg_inv(cfg_inv), .busy(busy), .out_valid(out_valid), .out_idx(out_idx),
    .op_count(op_count), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  int cap[256];  int ncap;  int cnt_end;  bit timed_out;
  int expv[256]; int nexp;
  int capl[256], capr[256], nl, nr;
  longint dat[64];

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int n, input int sub, input int inv, input int l, input int r);
    int v;
    v = sub[0] ? r : l;
    if (inv[0]) v = n - 1 - v;
    expv[nexp] = v; nexp++;
  endtask

  task automatic model(input int n, input int sub, input int inv);
    int p;
    nexp = 0;
    if (n < 2 || n > MAX_LEN) return;
    if (sub < 2) begin
      if (!inv[1]) begin
        for (int s = 2; s / 2 < n; s = s * 2)
          for (int i = 0; i + s / 2 < n; i = i + s) push(n, sub, inv, i, i + s / 2);
      end else begin
        p = 1; while (p * 2 < n) p = p * 2;
        for (int h = p; h >= 1; h = h / 2)
          for (int i = 0; i < h && i + h < n; i++) push(n, sub, inv, i, i + h);
      end
    end else begin
      for (int s = 2; s <= n; s = s * 2)
        for (int i = 0; i + s - 1 < n; i = i + s) push(n, sub, inv, i + s / 2 - 1, i + s - 1);
      p = 1; while (p * 2 <= n) p = p * 2;
      for (int s = p; s >= 2; s = s / 2)
        for (int i = 0; i + s + s / 2 - 1 < n; i = i + s) push(n, sub, inv, i + s - 1, i + s + s / 2 - 1);
    end
  endtask

  // poke: pulse start with other settings while busy (R10)
  task automatic run(input int n, input int sub, input int inv, input bit poke);
    int cyc;
    @(negedge clk);
    cfg_len = LEN_W'(n); cfg_sub = 2'(sub); cfg_inv = 2'(inv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ncap = 0; cyc = 0; timed_out = 1'b0;
    forever begin
      if (poke && cyc == 3) begin
        cfg_len = LEN_W'(3); cfg_sub = 2'b11; cfg_inv = 2'b01; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (out_valid) begin cap[ncap] = int'(out_idx); ncap++; end
      if (done) break;
      if (cyc > 400) begin timed_out = 1'b1; break; end
    end
    cnt_end = int'(op_count);
    check(!timed_out, "R8 completion", cyc, 0);
  endtask

  task automatic cmp_stream(input string req);
    check(ncap == nexp, req, ncap, nexp);
    for (int j = 0; j < ncap && j < nexp; j++) check(cap[j] == expv[j], req, cap[j], expv[j]);
    check(cnt_end == nexp, "R8 op_count", cnt_end, nexp);
  endtask

  task automatic sweep_one(input int n, input int fam, input int inv);
    string req;
    longint sum;
    if (fam == 0) req = inv[1] ? "R5" : "R3";
    else req = "R6";
    run(n, fam * 2, inv, 1'b0);
    model(n, fam * 2, inv); cmp_stream(req);
    for (int j = 0; j < ncap; j++) begin capl[j] = cap[j]; check(cap[j] < n, "R11", cap[j], n); end
    nl = ncap;
    run(n, fam * 2 + 1, inv, 1'b0);
    model(n, fam * 2 + 1, inv); cmp_stream(req);
    for (int j = 0; j < ncap; j++) begin capr[j] = cap[j]; check(cap[j] < n, "R11", cap[j], n); end
    nr = ncap;
    if (fam == 0) check(nl == n - 1, "R7 op total", nl, n - 1);
    for (int j = 0; j < nl && j < nr; j++)
      if (inv[0]) check(capl[j] > capr[j], "R4 order", capl[j], capr[j]);
      else        check(capl[j] < capr[j], "R4 order", capl[j], capr[j]);
    for (int k = 0; k < n; k++) dat[k] = longint'(k * k + 3);
    for (int j = 0; j < nl && j < nr; j++)
      if (fam == 0) dat[capl[j]] = dat[capl[j]] + dat[capr[j]];
      else          dat[capr[j]] = dat[capr[j]] + dat[capl[j]];
    if (fam == 0) begin
      sum = 0;
      for (int k = 0; k < n; k++) sum += longint'(k * k + 3);
      check(dat[inv[0] ? n - 1 : 0] == sum, inv[0] ? "R4 result" : req, dat[inv[0] ? n - 1 : 0], sum);
    end else begin
      for (int k = 0; k < n; k++) begin
        sum = 0;
        for (int m = 0; m < n; m++)
          if ((!inv[0] && m <= k) || (inv[0] && m >= k)) sum += longint'(m * m + 3);
        check(dat[k] == sum, "R6 scan", dat[k], sum);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog act=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !done, "R1 flags", {busy, out_valid, done}, 0);
    check(op_count == '0, "R1 count", op_count, 0);
    @(negedge clk) rst = 1'b0;
    check(!busy && !out_valid && !done && op_count == '0, "R1 after release", op_count, 0);

    // R2: explicit encodings for N=4
    run(4, 0, 0, 1'b0);
    check(ncap == 3 && cap[0] == 0 && cap[1] == 2 && cap[2] == 0, "R2 left", cap[1], 2);
    run(4, 1, 0, 1'b0);
    check(ncap == 3 && cap[0] == 1 && cap[1] == 3 && cap[2] == 2, "R2 right", cap[2], 2);

    // R7: single element
    run(1, 0, 0, 1'b0);
    check(ncap == 0 && cnt_end == 0, "R7 single", ncap, 0);

    // R9: rejected lengths
    run(0, 2, 0, 1'b0);
    check(ncap == 0 && cnt_end == 0, "R9 zero", ncap, 0);
    run(MAX_LEN + 1, 0, 0, 1'b0);
    check(ncap == 0 && cnt_end == 0, "R9 oversize", ncap, 0);

    // R10: start during a run
    run(8, 0, 0, 1'b1);
    model(8, 0, 0); cmp_stream("R10");

    // R8: longest scan stays within limit
    run(MAX_LEN, 3, 0, 1'b0);
    model(MAX_LEN, 3, 0); cmp_stream("R8 max");
    check(cnt_end <= 127, "R8 limit", cnt_end, 127);

    for (int n = 1; n <= 32; n++)
      for (int fam = 0; fam < 2; fam++)
        for (int inv = 0; inv < 4; inv++)
          sweep_one(n, fam, inv);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule